// File: doc/BRIEF.md
# Lazy Evidence Packet Ring

This block keeps a rolling window of the most recent packet descriptors. Each descriptor holds a flow identifier and a payload tag. Descriptors sit in a bounded circular store. Every accepted descriptor is written at the head. Once the store holds `RING_DEPTH` entries, each new arrival pushes the oldest entry out at the tail. `RING_DEPTH` is sized to cover the detection window: about 100,000 entries in a real deployment, and scaled down by the parameter for simulation.

A controller marks flows as malicious through a separate port. Each mark lands in a small fully associative table of bad flows. Marking triggers no search of the stored descriptors. Each descriptor is compared against the table only at the moment it leaves the tail. A match is presented on an evidence port that uses a valid/ready handshake. While evidence waits for a ready consumer, insertion stalls, so no evidence is lost.

Each table entry also counts the accepted packets of its flow since the entry was marked. The count is an 8-bit saturating value, read through a status port. Detecting intrusions and storing real payloads are outside the block.

Top module: `ev_lazy_ring`

## Requirements
- R1: A synchronous reset (`rst` high) empties the ring, clears every table entry and its counter, lowers `ev_valid` and `mark_overflow`, and leaves `in_ready` high.
- R2: While fewer than `RING_DEPTH` descriptors are held, an accepted descriptor is stored at the head and nothing is evicted, so no evidence appears, even for a marked flow.
- R3: With the ring full, each accepted descriptor evicts the oldest held descriptor. Evictions occur in insertion order, and the evicted descriptor is read before its slot is overwritten in the same cycle.
- R4: Marking a flow produces no evidence by itself. Packets of that flow already held appear only when they are later evicted.
- R5: When an evicted descriptor's flow is in the table (as registered before the evicting edge), `ev_valid` is high after that edge, with the evicted flow on `ev_flow` and its tag on `ev_tag`. An evicted descriptor of an unmarked flow is dropped silently.
- R6: A mark of a new flow fills the lowest-numbered free table entry. From the next cycle, the status port at that index shows valid=1, that flow, and count 0.
- R7: A mark of a flow already in the table changes no entry and does not raise `mark_overflow`.
- R8: A mark of a new flow while all `BAD_SLOTS` entries are valid is rejected, leaving the table unchanged. It sets `mark_overflow`, which stays high until reset.
- R9: Each accepted descriptor whose flow matches a valid entry adds one to that entry's count. The count saturates at 255 and stays there. Packets accepted before the mark are not counted.
- R10: While `ev_valid` is high and `ev_ready` is low, `in_ready` is low, no descriptor is accepted, and `ev_flow`/`ev_tag` hold steady.
- R11: Evidence is consumed on a cycle with `ev_valid` and `ev_ready` both high. `ev_valid` then falls, unless the same edge loads a new match, which allows back-to-back evidence every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Descriptor offered for insertion |
| in_flow | input | FLOW_W | Flow identifier of offered descriptor |
| in_tag | input | TAG_W | Payload tag of offered descriptor |
| in_ready | output | 1 | Insertion accepted this cycle when high with in_valid |
| mark_valid | input | 1 | Mark a flow as malicious |
| mark_flow | input | FLOW_W | Flow identifier to mark |
| mark_overflow | output | 1 | Sticky: a mark was rejected because the table was full |
| ev_valid | output | 1 | Evidence descriptor present |
| ev_ready | input | 1 | Consumer takes evidence |
| ev_flow | output | FLOW_W | Evidence flow identifier |
| ev_tag | output | TAG_W | Evidence payload tag |
| stat_idx | input | SIDX_W | Table entry selected for status read |
| stat_valid | output | 1 | Selected entry holds a flow |
| stat_flow | output | FLOW_W | Flow held in selected entry |
| stat_count | output | SUSP_W | Packet count of selected entry |

## Verification
The ring state shows at the ports only through evictions. A wrong head or tail pointer, or a wrong level count, therefore surfaces as evidence that comes too early during fill, in the wrong order, or with the wrong tag. It can stay hidden for up to `RING_DEPTH` insertions before the first eviction exposes it. Table faults show at once on the status port in the cycle after a mark: a wrong slot, a duplicate entry, or a missed overflow. A faulty counter shows there after one matching packet. Handshake faults show in the cycle they happen: lost or altered evidence under a low `ev_ready`, or a descriptor accepted during a stall that moves a counter.

// File: rtl/ev_lazy_pkg.sv
package ev_lazy_pkg;

   // outcome of a mark request against the bad-flow table
   typedef enum logic [1:0] {
      MARK_IDLE  = 2'd0,
      MARK_ALLOC = 2'd1,
      MARK_DUP   = 2'd2,
      MARK_FULL  = 2'd3
   } mark_res_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ev_ring_store.sv
module ev_ring_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned DW    = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [DW-1:0] wr_data,
   output logic          full,
   output logic [DW-1:0] tail_data
);
   localparam int unsigned PTR_W  = ev_lazy_pkg::idx_width(DEPTH);
   localparam int unsigned LVL_W  = $clog2(DEPTH + 1);
   localparam bit          IS_POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [DW-1:0]    mem_q [DEPTH];
   logic [PTR_W-1:0] head_q, tail_q, head_nxt, tail_nxt;
   logic [LVL_W-1:0] level_q;

   generate
      if (IS_POW2) begin : g_wrap_pow2
         assign head_nxt = head_q + 1'b1;
         assign tail_nxt = tail_q + 1'b1;
      end else begin : g_wrap_cmp
         assign head_nxt = (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + 1'b1;
         assign tail_nxt = (tail_q == PTR_W'(DEPTH - 1)) ? '0 : tail_q + 1'b1;
      end
   endgenerate

   assign full      = (level_q == LVL_W'(DEPTH));
   // combinational read: the evicted slot is seen before the write at the edge
   assign tail_data = mem_q[tail_q];

   always_ff @(posedge clk) begin
      if (push) mem_q[head_q] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q  <= '0;
         tail_q  <= '0;
         level_q <= '0;
      end else if (push) begin
         head_q <= head_nxt;
         if (full) tail_q  <= tail_nxt;
         else      level_q <= level_q + 1'b1;
      end
   end

endmodule

// File: rtl/ev_bad_table.sv
module ev_bad_table #(
   parameter int unsigned N  = 8,
   parameter int unsigned FW = 16,
   parameter int unsigned CW = 8,
   localparam int unsigned IW = ev_lazy_pkg::idx_width(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          mark_valid,
   input  logic [FW-1:0] mark_flow,
   input  logic          pkt_valid,
   input  logic [FW-1:0] pkt_flow,
   input  logic [FW-1:0] chk_flow,
   output logic          chk_hit,
   input  logic [IW-1:0] stat_idx,
   output logic          stat_valid,
   output logic [FW-1:0] stat_flow,
   output logic [CW-1:0] stat_count,
   output logic          overflow
);
   import ev_lazy_pkg::*;

   logic [N-1:0]  vld_q;
   logic [FW-1:0] flow_q [N];
   logic [CW-1:0] cnt_q  [N];

   logic          mark_hit, free_found;
   logic [IW-1:0] free_idx;
   mark_res_e     mark_res;

   always_comb begin
      mark_hit   = 1'b0;
      chk_hit    = 1'b0;
      free_found = 1'b0;
      free_idx   = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (vld_q[i] && flow_q[i] == mark_flow) mark_hit = 1'b1;
         if (vld_q[i] && flow_q[i] == chk_flow)  chk_hit  = 1'b1;
      end
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            free_found = 1'b1;
            free_idx   = IW'(i);
         end
      end
      if (!mark_valid)     mark_res = MARK_IDLE;
      else if (mark_hit)   mark_res = MARK_DUP;
      else if (free_found) mark_res = MARK_ALLOC;
      else                 mark_res = MARK_FULL;
   end

   generate
      for (genvar g = 0; g < int'(N); g++) begin : g_entry
         logic pkt_match;
         assign pkt_match = pkt_valid && vld_q[g] && (flow_q[g] == pkt_flow);
         always_ff @(posedge clk) begin
            if (rst) begin
               vld_q[g]  <= 1'b0;
               flow_q[g] <= '0;
               cnt_q[g]  <= '0;
            end else if (mark_res == MARK_ALLOC && free_idx == IW'(g)) begin
               vld_q[g]  <= 1'b1;
               flow_q[g] <= mark_flow;
               cnt_q[g]  <= '0;
            end else if (pkt_match && cnt_q[g] != '1) begin
               cnt_q[g] <= cnt_q[g] + 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                        overflow <= 1'b0;
      else if (mark_res == MARK_FULL) overflow <= 1'b1;
   end

   always_comb begin
      if (int'(stat_idx) < int'(N)) begin
         stat_valid = vld_q[stat_idx];
         stat_flow  = flow_q[stat_idx];
         stat_count = cnt_q[stat_idx];
      end else begin
         stat_valid = 1'b0;
         stat_flow  = '0;
         stat_count = '0;
      end
   end

endmodule

// File: rtl/ev_out_reg.sv
module ev_out_reg #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [DW-1:0] load_data,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] data
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= load_data;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/ev_lazy_ring.sv
module ev_lazy_ring #(
   parameter int unsigned RING_DEPTH = 64,
   parameter int unsigned FLOW_W     = 16,
   parameter int unsigned TAG_W      = 16,
   parameter int unsigned BAD_SLOTS  = 8,
   parameter int unsigned SUSP_W     = 8,
   localparam int unsigned SIDX_W    = ev_lazy_pkg::idx_width(BAD_SLOTS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [FLOW_W-1:0] in_flow,
   input  logic [TAG_W-1:0]  in_tag,
   output logic              in_ready,
   input  logic              mark_valid,
   input  logic [FLOW_W-1:0] mark_flow,
   output logic              mark_overflow,
   output logic              ev_valid,
   input  logic              ev_ready,
   output logic [FLOW_W-1:0] ev_flow,
   output logic [TAG_W-1:0]  ev_tag,
   input  logic [SIDX_W-1:0] stat_idx,
   output logic              stat_valid,
   output logic [FLOW_W-1:0] stat_flow,
   output logic [SUSP_W-1:0] stat_count
);
   localparam int unsigned DESC_W = FLOW_W + TAG_W;

   generate
      if (RING_DEPTH < 2)             begin : g_bad_depth $error("RING_DEPTH must be at least 2"); end
      if (BAD_SLOTS < 1)              begin : g_bad_slots $error("BAD_SLOTS must be at least 1"); end
      if (FLOW_W < 1 || TAG_W < 1)    begin : g_bad_width $error("FLOW_W and TAG_W must be positive"); end
      if (SUSP_W < 1)                 begin : g_bad_susp  $error("SUSP_W must be positive"); end
   endgenerate

   logic              accept, ring_full, evict, ev_load;
   logic [DESC_W-1:0] tail_desc, ev_desc;
   logic [FLOW_W-1:0] tail_flow;
   logic              tail_bad;

   // insertion pauses while undelivered evidence would be overwritten
   assign in_ready  = !ev_valid || ev_ready;
   assign accept    = in_valid && in_ready;
   assign evict     = accept && ring_full;
   assign tail_flow = tail_desc[DESC_W-1 -: FLOW_W];
   assign ev_load   = evict && tail_bad;

   ev_ring_store #(.DEPTH(RING_DEPTH), .DW(DESC_W)) ring_i (
      .clk       (clk),
      .rst       (rst),
      .push      (accept),
      .wr_data   ({in_flow, in_tag}),
      .full      (ring_full),
      .tail_data (tail_desc)
   );

   ev_bad_table #(.N(BAD_SLOTS), .FW(FLOW_W), .CW(SUSP_W)) table_i (
      .clk        (clk),
      .rst        (rst),
      .mark_valid (mark_valid),
      .mark_flow  (mark_flow),
      .pkt_valid  (accept),
      .pkt_flow   (in_flow),
      .chk_flow   (tail_flow),
      .chk_hit    (tail_bad),
      .stat_idx   (stat_idx),
      .stat_valid (stat_valid),
      .stat_flow  (stat_flow),
      .stat_count (stat_count),
      .overflow   (mark_overflow)
   );

   ev_out_reg #(.DW(DESC_W)) out_i (
      .clk       (clk),
      .rst       (rst),
      .load      (ev_load),
      .load_data (tail_desc),
      .ready     (ev_ready),
      .valid     (ev_valid),
      .data      (ev_desc)
   );

   assign ev_flow = ev_desc[DESC_W-1 -: FLOW_W];
   assign ev_tag  = ev_desc[TAG_W-1:0];

endmodule

// File: rtl/ev_lazy_ring_chk.sv
module ev_lazy_ring_chk #(
   parameter int unsigned FLOW_W = 16,
   parameter int unsigned TAG_W  = 16,
   parameter int unsigned SUSP_W = 8,
   parameter int unsigned SIDX_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              in_ready,
   input logic              mark_overflow,
   input logic              ev_valid,
   input logic              ev_ready,
   input logic [FLOW_W-1:0] ev_flow,
   input logic [TAG_W-1:0]  ev_tag,
   input logic [SIDX_W-1:0] stat_idx,
   input logic              stat_valid,
   input logic [SUSP_W-1:0] stat_count
);
   AST_RST_CLEAN: assert property (@(posedge clk)
      rst |=> (!ev_valid && !mark_overflow && in_ready));                          // R1

   AST_EV_SOURCE: assert property (@(posedge clk) disable iff (rst)
      $rose(ev_valid) |-> $past(in_valid && in_ready));                            // R5

   AST_EV_HOLD: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_flow) && $stable(ev_tag))); // R10

   AST_EV_DRAIN: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_ready && !in_valid) |=> !ev_valid);                          // R11

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      mark_overflow |=> mark_overflow);                                            // R8

   AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
      (stat_valid && stat_count == '1) |=> (!$stable(stat_idx) || stat_count == '1)); // R9

endmodule

bind ev_lazy_ring ev_lazy_ring_chk #(
   .FLOW_W(FLOW_W), .TAG_W(TAG_W), .SUSP_W(SUSP_W), .SIDX_W(SIDX_W)
) chk_i (
   .clk           (clk),
   .rst           (rst),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .mark_overflow (mark_overflow),
   .ev_valid      (ev_valid),
   .ev_ready      (ev_ready),
   .ev_flow       (ev_flow),
   .ev_tag        (ev_tag),
   .stat_idx      (stat_idx),
   .stat_valid    (stat_valid),
   .stat_count    (stat_count)
);

// File: tb/ev_lazy_ring_tb.sv
`timescale 1ns/1ps
module ev_lazy_ring_tb_top;
   localparam int DEPTH = 8;
   localparam int FW = 16;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic [FW-1:0] in_flow = '0;
   logic [TW-1:0] in_tag = '0;
   logic          in_ready;
   logic          mark_valid = 1'b0;
   logic [FW-1:0] mark_flow = '0;
   logic          mark_overflow;
   logic          ev_valid;
   logic          ev_ready = 1'b1;
   logic [FW-1:0] ev_flow;
   logic [TW-1:0] ev_tag;
   logic [2:0]    stat_idx = '0;
   logic          stat_valid;
   logic [FW-1:0] stat_flow;
   logic [7:0]    stat_count;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   ev_lazy_ring #(.RING_DEPTH(DEPTH), .FLOW_W(FW), .TAG_W(TW), .BAD_SLOTS(8), .SUSP_W(8)) dut_i (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_flow(in_flow), .in_tag(in_tag), .in_ready(in_ready),
      .mark_valid(mark_valid), .mark_flow(mark_flow), .mark_overflow(mark_overflow),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_flow(ev_flow), .ev_tag(ev_tag),
      .stat_idx(stat_idx), .stat_valid(stat_valid), .stat_flow(stat_flow), .stat_count(stat_count)
   );

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(input logic [FW-1:0] f, input logic [TW-1:0] t);
      in_valid = 1'b1; in_flow = f; in_tag = t;
      step();
      in_valid = 1'b0;
   endtask

   task automatic mark(input logic [FW-1:0] f);
      mark_valid = 1'b1; mark_flow = f;
      step();
      mark_valid = 1'b0;
   endtask

   task automatic peek(input int idx);
      stat_idx = 3'(idx);
      #1;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      step(); step();
      rst = 1'b0;
      peek(0);
      chk_eq("R1 ev_valid", 32'(ev_valid), 0);
      chk_eq("R1 overflow", 32'(mark_overflow), 0);
      chk_eq("R1 in_ready", 32'(in_ready), 1);
      chk_eq("R1 entry0 valid", 32'(stat_valid), 0);
      chk_eq("R1 entry0 count", 32'(stat_count), 0);
   endtask

   task automatic t_mark_alloc();
      mark(16'h0011);
      peek(0);
      chk_eq("R6 entry0 valid", 32'(stat_valid), 1);
      chk_eq("R6 entry0 flow", 32'(stat_flow), 32'h11);
      chk_eq("R6 entry0 count", 32'(stat_count), 0);
      mark(16'h0011);
      peek(1);
      chk_eq("R7 dup leaves entry1 free", 32'(stat_valid), 0);
      chk_eq("R7 dup no overflow", 32'(mark_overflow), 0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < DEPTH; i++) begin
         push((i % 2 == 0) ? 16'h0011 : 16'h0022, 16'(i));
         chk_eq("R2 no evidence while filling", 32'(ev_valid), 0);
      end
      peek(0);
      chk_eq("R9 count of flow 11", 32'(stat_count), 4);
   endtask

   task automatic t_evict_order();
      for (int i = 0; i < DEPTH; i++) begin
         push(16'h0033, 16'(16'h100 + i));
         chk_eq("R5 evidence only for marked flow", 32'(ev_valid), (i % 2 == 0) ? 1 : 0);
         if (i % 2 == 0) begin
            chk_eq("R3 eviction order tag", 32'(ev_tag), 32'(i));
            chk_eq("R5 evidence flow", 32'(ev_flow), 32'h11);
         end
      end
   endtask

   task automatic t_lazy_mark();
      mark(16'h0033);
      chk_eq("R4 no evidence on mark", 32'(ev_valid), 0);
      step(); step();
      chk_eq("R4 still no evidence", 32'(ev_valid), 0);
      for (int i = 0; i < DEPTH; i++) begin
         push(16'h0044, 16'(16'h200 + i));
         chk_eq("R11 back-to-back valid", 32'(ev_valid), 1);
         chk_eq("R4 held packet reported at eviction", 32'(ev_tag), 32'(16'h100 + i));
      end
      step();
      chk_eq("R11 drained", 32'(ev_valid), 0);
      peek(1);
      chk_eq("R9 earlier packets not counted", 32'(stat_count), 0);
   endtask

   task automatic t_stall();
      mark(16'h0044);
      ev_ready = 1'b0;
      push(16'h0055, 16'h0300);
      chk_eq("R5 evidence tag 200", 32'(ev_tag), 32'h200);
      in_valid = 1'b1; in_flow = 16'h0011; in_tag = 16'h0301;
      #1;
      chk_eq("R10 in_ready low", 32'(in_ready), 0);
      step();
      peek(0);
      chk_eq("R10 evidence held", 32'(ev_tag), 32'h200);
      chk_eq("R10 evidence valid", 32'(ev_valid), 1);
      chk_eq("R10 no accept during stall", 32'(stat_count), 4);
      ev_ready = 1'b1;
      #1;
      chk_eq("R11 ready reopens input", 32'(in_ready), 1);
      step();
      in_valid = 1'b0;
      peek(0);
      chk_eq("R11 next evidence tag", 32'(ev_tag), 32'h201);
      chk_eq("R11 next evidence flow", 32'(ev_flow), 32'h44);
      chk_eq("R9 accepted after stall", 32'(stat_count), 5);
   endtask

   task automatic t_saturate();
      mark(16'h0066);
      for (int i = 0; i < 254; i++) push(16'h0066, 16'(i));
      peek(3);
      chk_eq("R9 count 254", 32'(stat_count), 254);
      push(16'h0066, 16'h0);
      chk_eq("R9 count 255", 32'(stat_count), 255);
      for (int i = 0; i < 5; i++) push(16'h0066, 16'h0);
      chk_eq("R9 saturated", 32'(stat_count), 255);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < 4; i++) mark(16'(16'h0070 + i));
      peek(7);
      chk_eq("R6 last slot flow", 32'(stat_flow), 32'h73);
      chk_eq("R8 no overflow yet", 32'(mark_overflow), 0);
      mark(16'h0011);
      chk_eq("R7 dup on full table", 32'(mark_overflow), 0);
      mark(16'h0080);
      chk_eq("R8 overflow raised", 32'(mark_overflow), 1);
      peek(7);
      chk_eq("R8 table unchanged", 32'(stat_flow), 32'h73);
      step(); step();
      chk_eq("R8 overflow sticky", 32'(mark_overflow), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_mark_alloc();
      t_fill();
      t_evict_order();
      t_lazy_mark();
      t_stall();
      t_saturate();
      t_overflow();
      t_reset();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule